// File: doc/BRIEF.md
# Banked Wavefront Scratchpad with Transposed Tile Reads

This block is a software-managed local memory shared by all lanes of one wavefront. Storage is split into a power-of-two number of 32-bit banks. Each request carries one dword address per lane, a per-lane active mask and an operation code. The operation is a gather read, a scatter write, or a transposed tile read. A bank-to-lane crossbar lets every lane fetch from any bank in any order. When active lanes need different words from one bank, the access is spread over extra passes, with one word per bank per pass.

The transposed read takes a square tile of dwords stored row-major at a tile-aligned base. Lane order walks down the columns, so a kernel that wants column data sees it as consecutive lanes. The transposed read only rewrites the per-lane addresses in front of the shared arbiter and crossbar; no separate datapath is used. Requests enter through a valid/ready handshake. Results come back with a one-cycle done pulse after the final pass.

Top module: `banked_scratch`

## Requirements
- R1: A dword address splits into a bank index (its low log2(BANKS) bits) and a row inside that bank (the next log2(ROWS) bits); defaults are 16 banks of 16 rows and 16 lanes.
- R2: `req_ready` is high only while the block is idle. A request is taken on a rising edge where `req_valid` and `req_ready` are both high. Ready stays low from that edge until the edge after the done pulse.
- R3: For a request needing P passes, `rsp_valid` is high for exactly one cycle, beginning after the (P+1)-th rising edge when the accepting edge is counted as the first.
- R4: With op code 0 (read), every active lane receives the word stored at its own address, whatever bank that address falls in. Arbitrary lane-to-bank swizzles with no repeated bank complete in one pass.
- R5: Lanes reading the same address are served together, so a broadcast to all lanes takes one pass.
- R6: P equals the largest count, over all banks, of distinct rows addressed by active lanes in that bank, with a minimum of 1.
- R7: Inactive lanes neither write nor read; their `rsp_data` lane is zero. An op code 1 (write) returns all-zero data, and an empty mask still takes one pass.
- R8: When several active lanes write the same address, the data of the highest-numbered of them is stored.
- R9: Op code 2 (transposed read) uses lane 0's address as base. Lane l reads base + (l mod 4)*4 + floor(l/4) from a 4x4 tile, under the mask, in one pass.
- R10: For op code 2 with a base whose low 4 bits are not zero, no read is made. `rsp_valid` rises after the accepting edge itself with `rsp_err` high and all data zero; every other request returns `rsp_err` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_op | input | 2 | 0 read, 1 write, 2 transposed read, 3 read |
| req_mask | input | LANES | Per-lane active bits |
| req_addr | input | LANES*AW | Per-lane dword address, lane 0 in the low bits |
| req_wdata | input | LANES*32 | Per-lane write data |
| rsp_valid | output | 1 | One-cycle done pulse |
| rsp_err | output | 1 | Misaligned tile base, valid with rsp_valid |
| rsp_data | output | LANES*32 | Per-lane read data |

## Verification
The bench predicts the pass count for each request from its own per-bank tally of distinct rows. From that count it expects the done pulse P+1 edges after issue, or one edge for a rejected tile. It drives inputs on falling edges and counts rising edges until it sees `rsp_valid` at a falling edge, so the measured latency is an exact edge count. Data is compared at that falling edge against a shadow memory that the bench updates with its own highest-lane-wins rule.

// File: rtl/bscr_pkg.sv
package bscr_pkg;
  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_XPOSE = 2'd2,
    OP_RSVD  = 2'd3
  } op_e;

  // Offset inside a row-major square tile that lane `lane` fetches
  // when columns are delivered lane by lane.
  function automatic int unsigned tile_offset(input int unsigned lane,
                                              input int unsigned side);
    return (lane % side) * side + (lane / side);
  endfunction
endpackage

// File: rtl/bscr_addr_gen.sv
module bscr_addr_gen
  import bscr_pkg::*;
#(
  parameter int LANES = 16,
  parameter int AW    = 8,
  parameter int TILE  = 4
) (
  input  logic [1:0]          op,
  input  logic [LANES*AW-1:0] addr_in,
  output logic [LANES*AW-1:0] addr_out,
  output logic                misaligned
);
  localparam int TT = TILE * TILE;
  localparam int TW = $clog2(TT);

  logic [AW-1:0] base;
  logic          xpose;

  assign base       = addr_in[AW-1:0];
  assign xpose      = (op == OP_XPOSE);
  assign misaligned = xpose && (base[TW-1:0] != '0);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    localparam int unsigned OFF = (l < TT) ? tile_offset(l, TILE) : 0;
    assign addr_out[l*AW +: AW] = xpose ? (base + AW'(OFF)) : addr_in[l*AW +: AW];
  end
endmodule

// File: rtl/bscr_arbiter.sv
module bscr_arbiter #(
  parameter int LANES = 16,
  parameter int BANKS = 16,
  parameter int ROWS  = 16
) (
  input  logic [LANES-1:0]                         pending,
  input  logic [LANES*($clog2(BANKS)+$clog2(ROWS))-1:0] addr,
  output logic [LANES-1:0]                         grant,
  output logic [BANKS-1:0]                         bank_en,
  output logic [BANKS*$clog2(ROWS)-1:0]            bank_row,
  output logic [BANKS*$clog2(LANES)-1:0]           bank_wlane
);
  localparam int BW = $clog2(BANKS);
  localparam int RW = $clog2(ROWS);
  localparam int AW = BW + RW;
  localparam int LW = $clog2(LANES);

  // Each bank serves the row of its lowest-numbered pending lane.
  always_comb begin
    bank_en  = '0;
    bank_row = '0;
    for (int l = LANES - 1; l >= 0; l--) begin
      if (pending[l]) begin
        bank_en[addr[l*AW +: BW]]              = 1'b1;
        bank_row[addr[l*AW +: BW]*RW +: RW]    = addr[l*AW+BW +: RW];
      end
    end
  end

  // Every pending lane that wants the chosen row is served (broadcast).
  always_comb begin
    grant = '0;
    for (int l = 0; l < LANES; l++) begin
      grant[l] = pending[l] && bank_en[addr[l*AW +: BW]] &&
                 (bank_row[addr[l*AW +: BW]*RW +: RW] == addr[l*AW+BW +: RW]);
    end
  end

  // Write source per bank: highest granted lane.
  always_comb begin
    bank_wlane = '0;
    for (int l = 0; l < LANES; l++) begin
      if (grant[l]) bank_wlane[addr[l*AW +: BW]*LW +: LW] = LW'(l);
    end
  end
endmodule

// File: rtl/bscr_bank.sv
module bscr_bank #(
  parameter int ROWS = 16
) (
  input  logic                    clk,
  input  logic                    we,
  input  logic [$clog2(ROWS)-1:0] row,
  input  logic [31:0]             wdata,
  output logic [31:0]             rdata
);
  logic [31:0] mem [ROWS];

  always_ff @(posedge clk) begin
    if (we) mem[row] <= wdata;
  end

  assign rdata = mem[row];
endmodule

// File: rtl/bscr_xbar.sv
module bscr_xbar #(
  parameter int LANES = 16,
  parameter int BANKS = 16
) (
  input  logic [BANKS*32-1:0]             bank_rdata,
  input  logic [LANES*$clog2(BANKS)-1:0]  lane_bank,
  output logic [LANES*32-1:0]             lane_rdata
);
  localparam int BW = $clog2(BANKS);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane_rdata[l*32 +: 32] = bank_rdata[lane_bank[l*BW +: BW]*32 +: 32];
  end
endmodule

// File: rtl/banked_scratch.sv
module banked_scratch
  import bscr_pkg::*;
#(
  parameter int LANES = 16,
  parameter int BANKS = 16,
  parameter int ROWS  = 16,
  parameter int TILE  = 4,
  localparam int BW   = $clog2(BANKS),
  localparam int RW   = $clog2(ROWS),
  localparam int AW   = BW + RW,
  localparam int LW   = $clog2(LANES)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [1:0]          req_op,
  input  logic [LANES-1:0]    req_mask,
  input  logic [LANES*AW-1:0] req_addr,
  input  logic [LANES*32-1:0] req_wdata,
  output logic                rsp_valid,
  output logic                rsp_err,
  output logic [LANES*32-1:0] rsp_data
);
  typedef enum logic [1:0] {S_IDLE, S_BUSY, S_DONE} state_e;

  state_e              state;
  logic                is_write_q;
  logic [LANES*AW-1:0] addr_q;
  logic [LANES*32-1:0] wdata_q;
  logic [LANES-1:0]    pending_q;
  logic [LANES*32-1:0] result_q;
  logic                err_q;
  logic                rsp_valid_q;

  // Named internal events
  logic                accept;
  logic                busy;
  logic                last_pass;
  logic [LANES-1:0]    grant;
  logic [LANES-1:0]    pending_next;
  logic [BANKS-1:0]    bank_en;
  logic [BANKS*RW-1:0] bank_row;
  logic [BANKS*LW-1:0] bank_wlane;
  logic [LANES*AW-1:0] eff_addr;
  logic                misaligned;
  logic [LANES*BW-1:0] lane_bank;
  logic [BANKS*32-1:0] bank_rdata;
  logic [LANES*32-1:0] lane_rdata;

  assign req_ready    = (state == S_IDLE);
  assign accept       = req_valid && req_ready;
  assign busy         = (state == S_BUSY);
  assign pending_next = pending_q & ~grant;
  assign last_pass    = busy && (pending_next == '0);

  bscr_addr_gen #(.LANES(LANES), .AW(AW), .TILE(TILE)) u_agen (
    .op        (req_op),
    .addr_in   (req_addr),
    .addr_out  (eff_addr),
    .misaligned(misaligned)
  );

  bscr_arbiter #(.LANES(LANES), .BANKS(BANKS), .ROWS(ROWS)) u_arb (
    .pending   (pending_q),
    .addr      (addr_q),
    .grant     (grant),
    .bank_en   (bank_en),
    .bank_row  (bank_row),
    .bank_wlane(bank_wlane)
  );

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic        we;
    logic [31:0] wd;
    assign we = busy && is_write_q && bank_en[b];
    assign wd = wdata_q[bank_wlane[b*LW +: LW]*32 +: 32];
    bscr_bank #(.ROWS(ROWS)) u_bank (
      .clk  (clk),
      .we   (we),
      .row  (bank_row[b*RW +: RW]),
      .wdata(wd),
      .rdata(bank_rdata[b*32 +: 32])
    );
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lbank
    assign lane_bank[l*BW +: BW] = addr_q[l*AW +: BW];
  end

  bscr_xbar #(.LANES(LANES), .BANKS(BANKS)) u_xbar (
    .bank_rdata(bank_rdata),
    .lane_bank (lane_bank),
    .lane_rdata(lane_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      is_write_q  <= 1'b0;
      addr_q      <= '0;
      wdata_q     <= '0;
      pending_q   <= '0;
      result_q    <= '0;
      err_q       <= 1'b0;
      rsp_valid_q <= 1'b0;
    end else begin
      case (state)
        S_IDLE: begin
          rsp_valid_q <= 1'b0;
          if (accept) begin
            result_q   <= '0;
            err_q      <= misaligned;
            addr_q     <= eff_addr;
            wdata_q    <= req_wdata;
            is_write_q <= (req_op == OP_WRITE);
            if (misaligned) begin
              pending_q   <= '0;
              rsp_valid_q <= 1'b1;
              state       <= S_DONE;
            end else begin
              pending_q <= req_mask;
              state     <= S_BUSY;
            end
          end
        end
        S_BUSY: begin
          for (int l = 0; l < LANES; l++) begin
            if (!is_write_q && grant[l]) result_q[l*32 +: 32] <= lane_rdata[l*32 +: 32];
          end
          pending_q <= pending_next;
          if (last_pass) begin
            rsp_valid_q <= 1'b1;
            state       <= S_DONE;
          end
        end
        default: begin
          rsp_valid_q <= 1'b0;
          state       <= S_IDLE;
        end
      endcase
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_err   = rsp_valid_q && err_q;
  assign rsp_data  = result_q;
endmodule

// File: rtl/bscr_checker.sv
module bscr_checker #(
  parameter int LANES = 16,
  parameter int AW    = 8,
  parameter int TILE  = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic [1:0]       req_op,
  input logic [AW-1:0]    base,
  input logic             rsp_valid,
  input logic             rsp_err,
  input logic             busy,
  input logic [LANES-1:0] pending,
  input logic [LANES-1:0] grant
);
  localparam int TW = $clog2(TILE * TILE);

  AST_GRANT_IN_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> ((grant & ~pending) == '0)); // R6

  AST_PASS_PROGRESS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && pending != '0) |-> (grant != '0)); // R6

  AST_NO_READY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy || rsp_valid) |-> !req_ready); // R2

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R3

  AST_MISALIGN_FAST_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_op == 2'd2 && base[TW-1:0] != '0)
      |=> (rsp_valid && rsp_err)); // R10
endmodule

bind banked_scratch bscr_checker #(.LANES(LANES), .AW(AW), .TILE(TILE)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_valid(req_valid),
  .req_ready(req_ready),
  .req_op   (req_op),
  .base     (req_addr[AW-1:0]),
  .rsp_valid(rsp_valid),
  .rsp_err  (rsp_err),
  .busy     (busy),
  .pending  (pending_q),
  .grant    (grant)
);

// File: tb/banked_scratch_tb_top.sv
module banked_scratch_tb_top;
  localparam int L  = 16;
  localparam int AW = 8;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            req_valid = 1'b0;
  logic            req_ready;
  logic [1:0]      req_op = '0;
  logic [L-1:0]    req_mask = '0;
  logic [L*AW-1:0] req_addr = '0;
  logic [L*32-1:0] req_wdata = '0;
  logic            rsp_valid;
  logic            rsp_err;
  logic [L*32-1:0] rsp_data;

  int total = 0;
  int failed = 0;
  bit finished = 0;

  logic [31:0] model [256];
  int          a_lane [L];
  logic [31:0] d_lane [L];

  always #5 clk = ~clk;

  banked_scratch dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_mask(req_mask), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_data(rsp_data)
  );

  task automatic check(input string rq, input string what,
                       input longint act, input longint exp);
    total++;
    if (act != exp) begin
      failed++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  function automatic logic [31:0] pat(input int a, input int salt);
    return (32'(a) * 32'h9E3779B1) ^ (32'(salt) << 8) ^ 32'h5A;
  endfunction

  task automatic issue(input int op, input logic [L-1:0] mask, input string rq);
    int eff [L];
    logic [31:0] expd [L];
    int rows_seen [16][16];
    int cnt [16];
    int p, n, exp_lat, bad;
    bit mis;
    logic [L*32-1:0] got;
    logic got_err;
    mis = (op == 2) && ((a_lane[0] % 16) != 0);
    for (int l = 0; l < L; l++)
      eff[l] = (op == 2) ? ((a_lane[0] + (l % 4) * 4 + l / 4) & 255) : a_lane[l];
    for (int b = 0; b < 16; b++) begin
      cnt[b] = 0;
      for (int r = 0; r < 16; r++) rows_seen[b][r] = 0;
    end
    for (int l = 0; l < L; l++)
      if (mask[l] && !rows_seen[eff[l] % 16][eff[l] / 16]) begin
        rows_seen[eff[l] % 16][eff[l] / 16] = 1;
        cnt[eff[l] % 16]++;
      end
    p = 1;
    for (int b = 0; b < 16; b++) if (cnt[b] > p) p = cnt[b];
    for (int l = 0; l < L; l++)
      expd[l] = (!mis && op != 1 && mask[l]) ? model[eff[l]] : 32'h0;
    exp_lat = mis ? 1 : p + 1;
    req_op = 2'(op);
    req_mask = mask;
    for (int l = 0; l < L; l++) begin
      req_addr[l*AW +: AW] = AW'(a_lane[l]);
      req_wdata[l*32 +: 32] = d_lane[l];
    end
    req_valid = 1'b1;
    n = 0;
    while (n < 64) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      if (n == 1) req_valid = 1'b0;
      if (rsp_valid) break;
    end
    got = rsp_data;
    got_err = rsp_err;
    check(rq, "done latency", n, exp_lat);
    check("R10", "error flag", got_err, mis);
    bad = -1;
    for (int l = L - 1; l >= 0; l--) if (got[l*32 +: 32] !== expd[l]) bad = l;
    if (bad >= 0) check(rq, $sformatf("lane %0d data", bad), got[bad*32 +: 32], expd[bad]);
    else check(rq, "lane data", 0, 0);
    if (op == 1 && !mis)
      for (int l = 0; l < L; l++) if (mask[l]) model[eff[l]] = d_lane[l];
    @(posedge clk);
    @(negedge clk);
    check("R2", "ready after done", req_ready, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      failed++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) model[i] = 32'h0;
    repeat (3) @(negedge clk);
    check("R2", "reset ready", req_ready, 1);
    check("R3", "reset done", rsp_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R7: fill memory one row at a time, each lane a different bank
    for (int r = 0; r < 16; r++) begin
      for (int l = 0; l < L; l++) begin a_lane[l] = r * 16 + l; d_lane[l] = pat(r * 16 + l, 1); end
      issue(1, '1, "R7");
    end
    // R4: swizzled reads, distinct banks
    for (int r = 0; r < 16; r++) begin
      for (int l = 0; l < L; l++) a_lane[l] = r * 16 + ((l * 5 + 3) & 15);
      issue(0, '1, "R4");
    end
    // R5: broadcast
    for (int a = 0; a < 256; a += 37) begin
      for (int l = 0; l < L; l++) a_lane[l] = a;
      issue(0, '1, "R5");
    end
    // R6 R1: k distinct rows in a single bank
    for (int k = 1; k <= 16; k++) begin
      for (int l = 0; l < L; l++) a_lane[l] = (l % k) * 16 + (k % 16);
      issue(0, '1, "R6");
    end
    // R6 R7: mixed addresses under masks
    for (int i = 0; i < 16; i++) begin
      for (int l = 0; l < L; l++) a_lane[l] = (l * 7 + i * 29 + l * l * i) & 255;
      issue(0, 16'hA5A5 ^ (16'h1 << i), "R6");
    end
    // R7: empty mask
    issue(0, '0, "R7");
    // R8: write conflicts
    for (int l = 0; l < L; l++) begin a_lane[l] = 37; d_lane[l] = pat(l, 9); end
    issue(1, '1, "R8");
    issue(0, '1, "R8");
    for (int l = 0; l < L; l++) begin a_lane[l] = (l < 8) ? 90 : 106; d_lane[l] = pat(l, 11); end
    issue(1, 16'h0370, "R8");
    issue(0, '1, "R8");
    // R9: transposed tile reads
    for (int t = 0; t < 16; t++) begin
      for (int l = 0; l < L; l++) a_lane[l] = t * 16;
      issue(2, '1, "R9");
    end
    issue(2, 16'h0F0F, "R9");
    // R10: misaligned tile bases
    for (int off = 1; off < 16; off++) begin
      for (int l = 0; l < L; l++) a_lane[l] = 32 + off;
      issue(2, '1, "R10");
    end

    finished = 1;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule